// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serial Shifter

This block is a chain of storage stages. On a rising clock edge the chain either takes a whole word from a parallel bus or advances one position, with a new bit entering from a serial input. A mode pin chooses between the two actions. A hold pin lets the clock run freely while the chain keeps its contents. An active-low clear empties every stage at once, and it does not wait for the clock. Only the far end of the chain drives the data output. A debug port shows every stage so that a bench can compare the whole chain against a model.

The hold pin is sampled at the clock edge and works as a synchronous enable. It is never combined with the clock, so it can change at any time outside the setup window. Stage 0 sits next to the serial input. Stage `WIDTH-1` drives the output. Parallel bit k loads into stage k. After a load, the output therefore shows `parIn[WIDTH-1]` first and `parIn[0]` last.

Top module: `gated_shift_reg`

## Requirements
- R1: While `clearN` is low, every stage and `serialOut` read 0. This takes effect within the same cycle that `clearN` falls, without any clock edge.
- R2: While `clearN` is low, clock edges have no effect. This holds for any mode, hold, serial or parallel input, and the chain stays all zero.
- R3: When `shiftMode`=1 and `holdIn`=0, a rising edge moves `serialIn` into stage 0 and each stage k-1 into stage k.
- R4: When `shiftMode`=0 and `holdIn`=0, a rising edge copies `parIn[k]` into stage k for every k. Before that edge, the stages do not change.
- R5: During a parallel load, `serialIn` has no effect on any stage.
- R6: When `holdIn`=1, a rising edge leaves every stage unchanged, whatever the mode, serial and parallel inputs are.
- R7: Between rising edges, with `clearN` high, the stages keep their values while any other input changes.
- R8: `serialOut` always equals stage `WIDTH-1`. After a load followed by shifts, it presents `parIn[WIDTH-1]` down to `parIn[0]` on successive shift edges.
- R9: Hold edges placed in the middle of a shift sequence neither drop a bit nor repeat one in the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clearN | input | 1 | Asynchronous clear, active low |
| shiftMode | input | 1 | 1 = shift, 0 = parallel load |
| holdIn | input | 1 | 1 = keep contents on this edge |
| serialIn | input | 1 | Bit entering stage 0 when shifting |
| parIn | input | WIDTH | Parallel word; bit k goes to stage k |
| serialOut | output | 1 | Contents of stage WIDTH-1 |
| stageDbg | output | WIDTH | All stages, bit k = stage k |

## Verification
The directed patterns come first. Alternating and all-ones words are loaded and then shifted out, which shows whether the bit order on the output runs the right way. A load with the serial input toggling separates load from shift. A run of hold edges inside a shift stream catches a lost or repeated bit. Clear is pulsed between edges and held across edges, which separates the asynchronous clear from a synchronous one. After these, a long seeded random mix of all modes is compared against a bench model, stage by stage.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef struct packed {
    logic loadStb;
    logic shiftStb;
  } shiftCmd_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic      shiftMode,
  input  logic      holdIn,
  output shiftCmd_t cmd
);
  // Hold is a synchronous enable: it only suppresses the strobes.
  always_comb begin
    cmd.loadStb  = !holdIn && !shiftMode;
    cmd.shiftStb = !holdIn && shiftMode;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  shiftCmd_t        cmd,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftSrc;
  assign shiftSrc = {stageQ[LAST-1:0], serialIn};

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge clearN) begin
      if (!clearN)           stageQ[k] <= 1'b0;
      else if (cmd.loadStb)  stageQ[k] <= parIn[k];
      else if (cmd.shiftStb) stageQ[k] <= shiftSrc[k];
    end
  end

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(cmd.shiftStb)) |->
      stageQ == {$past(stageQ[LAST-1:0]), $past(serialIn)});

  // R4
  load_capture_chk: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(cmd.loadStb)) |-> stageQ == $past(parIn));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(!cmd.loadStb && !cmd.shiftStb)) |-> $stable(stageQ));
endmodule

// File: rtl/gated_shift_reg.sv
module gated_shift_reg
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             shiftMode,
  input  logic             holdIn,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serialOut,
  output logic [WIDTH-1:0] stageDbg
);
  shiftCmd_t cmd;
  logic [WIDTH-1:0] stageQ;

  shift_ctrl u_ctrl (
    .shiftMode(shiftMode),
    .holdIn   (holdIn),
    .cmd      (cmd)
  );

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .clearN  (clearN),
    .cmd     (cmd),
    .serialIn(serialIn),
    .parIn   (parIn),
    .stageQ  (stageQ)
  );

  assign serialOut = stageQ[WIDTH-1];
  assign stageDbg  = stageQ;

  // R8
  out_advance_chk: assert property (@(posedge clk) disable iff (!clearN)
    ($past(clearN) && $past(shiftMode && !holdIn)) |->
      serialOut == $past(stageDbg[WIDTH-2]));
endmodule

// File: tb/gated_shift_reg_tb.sv
module gated_shift_reg_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clearN, shiftMode, holdIn, serialIn;
  logic [W-1:0] parIn;
  logic serialOut;
  logic [W-1:0] stageDbg;
  logic [W-1:0] model;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gated_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .clearN(clearN), .shiftMode(shiftMode), .holdIn(holdIn),
    .serialIn(serialIn), .parIn(parIn), .serialOut(serialOut), .stageDbg(stageDbg)
  );

  function automatic logic [W-1:0] nextModel(logic [W-1:0] cur, logic m,
      logic h, logic s, logic [W-1:0] p);
    if (h)      return cur;
    else if (m) return {cur[W-2:0], s};
    else        return p;
  endfunction

  task automatic check(logic [W-1:0] act, logic [W-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, apply one rising edge, compare at next negedge
  task automatic step(logic m, logic h, logic s, logic [W-1:0] p, string req);
    shiftMode = m; holdIn = h; serialIn = s; parIn = p;
    @(posedge clk);
    model = nextModel(model, m, h, s, p);
    @(negedge clk);
    check(stageDbg, model, req);
    check({{(W-1){1'b0}}, serialOut}, {{(W-1){1'b0}}, model[W-1]}, {req, " R8 out"});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] word;
    logic [W-1:0] got;
    void'($urandom(32'h5eed));
    clearN = 1'b0; shiftMode = 1'b0; holdIn = 1'b0; serialIn = 1'b0; parIn = '0;
    model = '0;
    @(negedge clk); @(negedge clk);
    check(stageDbg, '0, "R1 reset");
    // R2: edge with clear low and load requested
    parIn = 8'hFF;
    @(posedge clk); @(negedge clk);
    check(stageDbg, '0, "R2 clear beats load");
    clearN = 1'b1;

    // R4: load, stage unchanged before edge
    shiftMode = 1'b0; parIn = 8'hA5; #1;
    check(stageDbg, '0, "R4 no load before edge");
    @(negedge clk);
    model = 8'hA5;
    check(stageDbg, model, "R4 load");

    // R8: bits leave MSB first over W edges
    for (int i = W - 1; i >= 0; i--) begin
      check({7'b0, serialOut}, {7'b0, word_bit(8'hA5, i)}, "R8 order");
      step(1'b1, 1'b0, 1'b0, 8'h00, "R3 shift");
    end

    // R5: serial toggling during load
    step(1'b0, 1'b0, 1'b1, 8'h3C, "R5 load ignores serial");
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R5 load all ones");

    // R7: inputs change between edges
    shiftMode = 1'b1; serialIn = 1'b0; parIn = 8'h00; #1;
    check(stageDbg, model, "R7 no edge");
    @(negedge clk);
    model = {model[W-2:0], 1'b0};
    check(stageDbg, model, "R3 shift in zero");

    // R9: hold edges in middle of a shift stream
    step(1'b0, 1'b0, 1'b0, 8'h96, "R4 load 96");
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], serialOut};
      if (i == 3)
        for (int j = 0; j < 4; j++)
          step(j[0], 1'b1, $urandom_range(0, 1), W'($urandom), "R6 hold");
      step(1'b1, 1'b0, 1'b0, 8'h00, "R3 shift");
    end
    check(got, 8'h96, "R9 stream intact");

    // R1: asynchronous clear between edges
    step(1'b0, 1'b0, 1'b0, 8'hE7, "R4 load E7");
    #1 clearN = 1'b0; #0.5;
    check(stageDbg, '0, "R1 async clear");
    check({7'b0, serialOut}, 8'h00, "R1 out zero");
    @(negedge clk); clearN = 1'b1; model = '0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        clearN = 1'b0; parIn = W'($urandom); shiftMode = $urandom_range(0, 1);
        @(posedge clk); @(negedge clk);
        model = '0;
        check(stageDbg, '0, "R2 random clear");
        clearN = 1'b1;
      end else begin
        step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 1), W'($urandom), "R3 R4 R6 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  function automatic logic word_bit(logic [W-1:0] w, int i);
    return w[i];
  endfunction
endmodule